// File: doc/BRIEF.md
# Packetised Video Pixel Stage

This stage sits in a packetised video stream between an upstream source and a downstream sink. Both sides carry a data bus, a valid flag, start-of-packet and end-of-packet markers, and a ready signal that runs one cycle ahead of the data it governs. A video packet opens with a single header beat whose data is a type identifier (zero for video). Pixel beats follow, top-left first, and the last pixel carries end-of-packet. The stage forwards the header untouched. It inverts every colour sample of each pixel beat and delivers the result, with its framing markers, three cycles after acceptance when the output is flowing.

Each pixel travels as three 8-bit samples side by side in one beat. A short pipeline carries the data and the framing flags together. Its last stage feeds a skid store, which holds beats whenever the sink has withdrawn ready. The input ready is derived from how many beats the stage holds, so a beat that has been accepted is never dropped.

Top module: `vps_stream_stage`

## Requirements
- R1: During reset and afterwards, until a new beat has been accepted, out_valid is low, and in_ready is high in the first cycle after reset. A reset discards every beat held in the stage.
- R2: An input beat is taken in cycle N only when in_valid is high in N and in_ready was high in N-1. Any other beat presented is ignored.
- R3: A beat with in_sop high is a header, and its 24-bit data leaves the stage bit for bit unchanged, whatever its value.
- R4: For a beat with in_sop low, each sample k held in data bits [8k+7:8k] (k = 0..2) is output as 255 minus its input value.
- R5: out_sop and out_eop accompany the same beat that carried in_sop and in_eop on input.
- R6: No beat leaves earlier than three cycles after it was taken. While out_ready has been held high throughout, every beat leaves exactly three cycles after it was taken.
- R7: out_valid is high in cycle N only if out_ready was high in N-1. Every cycle with out_valid high delivers one beat.
- R8: Beats leave in the order they were taken, with none lost or duplicated, however out_ready toggles.
- R9: A cycle with no input taken adds no output beat. Gaps in the input appear as gaps in the output.
- R10: in_ready is high in a cycle exactly when the number of beats held (taken but not yet delivered) plus 2 is at most SKID_DEPTH. With the sink stalled and the source always valid, the held count settles at SKID_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 24 | Header identifier or three 8-bit samples of one pixel |
| in_valid | input | 1 | Source presents a beat |
| in_sop | input | 1 | Beat is the packet header |
| in_eop | input | 1 | Beat is the final pixel |
| in_ready | output | 1 | Stage can take a beat in the next cycle |
| out_data | output | 24 | Forwarded header or processed pixel |
| out_valid | output | 1 | Stage delivers a beat this cycle |
| out_sop | output | 1 | Delivered beat is a header |
| out_eop | output | 1 | Delivered beat is the final pixel |
| out_ready | input | 1 | Sink can take a beat in the next cycle |

## Verification
The bench builds the stage with PIPE_STAGES = 3 and SKID_DEPTH = 8. At these sizes a stalled sink fills the skid store within about ten cycles, so the bench reaches the point where in_ready falls and then drains a completely full store. The three-stage depth makes the exact latency on a free-flowing output a fixed value that can be checked on every beat. Random packets with random gaps and random sink stalls exercise the order of beats across mixed direct and queued delivery. A reset issued while the store is full shows that held beats are discarded.

// File: rtl/vps_pkg.sv
package vps_pkg;

  localparam int SAMPLE_W    = 8;
  localparam int NUM_SAMPLES = 3;
  localparam int DATA_W      = SAMPLE_W * NUM_SAMPLES;

  typedef logic [DATA_W-1:0] pixel_t;

  typedef struct packed {
    logic   sop;
    logic   eop;
    pixel_t data;
  } beat_t;

  // Per-sample complement of one pixel.
  function automatic pixel_t invert_samples(input pixel_t px);
    pixel_t res;
    for (int k = 0; k < NUM_SAMPLES; k++) begin
      res[k*SAMPLE_W +: SAMPLE_W] = ~px[k*SAMPLE_W +: SAMPLE_W];
    end
    return res;
  endfunction

  // Header beats pass through; body beats get the pixel operation.
  function automatic pixel_t apply_op(input beat_t b);
    return b.sop ? b.data : invert_samples(b.data);
  endfunction

endpackage

// File: rtl/vps_pixel_pipe.sv
module vps_pixel_pipe
  import vps_pkg::*;
#(
  parameter int STAGES = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_vld,
  input  beat_t                            in_beat,
  output logic                             out_vld,
  output beat_t                            out_beat,
  output logic [$clog2(STAGES+1)-1:0]      occ
);

  localparam int OCC_W = $clog2(STAGES + 1);

  logic  [STAGES-1:0] vld_q;
  beat_t              beat_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      for (int i = 0; i < STAGES; i++) beat_q[i] <= '0;
    end else begin
      vld_q[0]  <= in_vld;
      beat_q[0] <= beat_t'{sop: in_beat.sop, eop: in_beat.eop, data: apply_op(in_beat)};
      for (int i = 1; i < STAGES; i++) begin
        vld_q[i]  <= vld_q[i-1];
        beat_q[i] <= beat_q[i-1];
      end
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < STAGES; i++) occ = occ + OCC_W'(vld_q[i]);
  end

  assign out_vld  = vld_q[STAGES-1];
  assign out_beat = beat_q[STAGES-1];

  // R3: a header entering stage one keeps its identifier intact
  p_hdr_intact_r3: assert property (@(posedge clk) disable iff (rst)
    (vld_q[0] && beat_q[0].sop) |-> (beat_q[0].data == $past(in_beat.data)));

  // R4: a body beat entering stage one is the bitwise complement of its input
  p_body_inverted_r4: assert property (@(posedge clk) disable iff (rst)
    (vld_q[0] && !beat_q[0].sop) |-> (beat_q[0].data == ~$past(in_beat.data)));

  // R9: an idle input cycle leaves the first stage empty
  p_gap_kept_r9: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !vld_q[0]);

endmodule

// File: rtl/vps_skid_fifo.sv
module vps_skid_fifo
  import vps_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push,
  input  beat_t                         push_beat,
  input  logic                          pop,
  output beat_t                         head_beat,
  output logic [$clog2(DEPTH+1)-1:0]    count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  beat_t             mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_beat = mem[rd_ptr];

  // R8: never write into a full store unless a beat leaves in the same cycle
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (push && (count == CNT_W'(DEPTH))) |-> pop);

  // R8: never read from an empty store
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));

endmodule

// File: rtl/vps_stream_stage.sv
module vps_stream_stage
  import vps_pkg::*;
#(
  parameter int PIPE_STAGES = 3,
  parameter int SKID_DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready
);

  localparam int CNT_W    = $clog2(SKID_DEPTH + 1);
  localparam int OCC_W    = $clog2(PIPE_STAGES + 1);
  localparam int HEADROOM = 2;   // one beat this cycle, one more granted by ready

  logic             in_ready_q, out_ready_q;
  logic             accept;
  beat_t            in_beat;
  logic             pipe_vld;
  beat_t            pipe_beat;
  logic [OCC_W-1:0] pipe_occ;
  logic             skid_push, skid_pop, skid_empty;
  beat_t            skid_head, sel_beat;
  logic [CNT_W-1:0] skid_count;

  // Ready is qualified one cycle later on both sides.
  always_ff @(posedge clk) begin
    if (rst) begin
      in_ready_q  <= 1'b0;
      out_ready_q <= 1'b0;
    end else begin
      in_ready_q  <= in_ready;
      out_ready_q <= out_ready;
    end
  end

  assign accept  = in_valid && in_ready_q;
  assign in_beat = beat_t'{sop: in_sop, eop: in_eop, data: in_data};

  vps_pixel_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (accept),
    .in_beat  (in_beat),
    .out_vld  (pipe_vld),
    .out_beat (pipe_beat),
    .occ      (pipe_occ)
  );

  assign skid_empty = (skid_count == '0);
  // Direct path when the store is empty and the sink may take a beat.
  assign skid_pop   = out_ready_q && !skid_empty;
  assign skid_push  = pipe_vld && !(out_ready_q && skid_empty);

  vps_skid_fifo #(.DEPTH(SKID_DEPTH)) u_skid (
    .clk       (clk),
    .rst       (rst),
    .push      (skid_push),
    .push_beat (pipe_beat),
    .pop       (skid_pop),
    .head_beat (skid_head),
    .count     (skid_count)
  );

  assign sel_beat  = skid_empty ? pipe_beat : skid_head;
  assign out_valid = out_ready_q && (!skid_empty || pipe_vld);
  assign out_data  = sel_beat.data;
  assign out_sop   = sel_beat.sop;
  assign out_eop   = sel_beat.eop;

  assign in_ready = (int'(skid_count) + int'(pipe_occ) + HEADROOM) <= SKID_DEPTH;

  // R7: delivery only after the sink signalled ready in the previous cycle
  p_out_gate_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_ready));

  // R2: a beat enters the pipeline only after in_ready was high a cycle earlier
  p_accept_gate_r2: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(in_ready));

endmodule

// File: tb/vps_stream_stage_test.sv
module vps_stream_stage_test;

  localparam int SW    = 8;
  localparam int NS    = 3;
  localparam int DW    = SW * NS;
  localparam int BW    = DW + 2;
  localparam int STG   = 3;
  localparam int SKID  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [DW-1:0] in_data = '0;
  logic          in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic          in_ready;
  logic [DW-1:0] out_data;
  logic          out_valid, out_sop, out_eop;
  logic          out_ready = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  vps_stream_stage #(.PIPE_STAGES(STG), .SKID_DEPTH(SKID)) uut (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_ready(out_ready)
  );

  int checks = 0, fails = 0;
  int cycle = 0, acc_cnt = 0, emit_cnt = 0, body_left = 0;
  logic prev_in_ready = 1'b0, prev_out_ready = 1'b0, exact_lat = 1'b0;
  logic s_ov = 1'b0;
  logic cur_sop = 1'b0, cur_eop = 1'b0;
  logic [DW-1:0] cur_data = '0;
  logic [BW-1:0] exp_q [$];
  int            cyc_q [$];

  function automatic logic [DW-1:0] exp_pixel(input logic [DW-1:0] d, input logic hdr);
    logic [DW-1:0] r;
    if (hdr) return d;
    for (int k = 0; k < NS; k++) r[k*SW +: SW] = 8'd255 - d[k*SW +: SW];
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cycle);
    end
  endtask

  task automatic load_next();
    if (body_left == 0) begin
      cur_sop   = 1'b1;
      cur_eop   = 1'b0;
      cur_data  = ($urandom % 4 == 0) ? DW'($urandom % 16) : '0;
      body_left = 1 + int'($urandom % 5);
    end else begin
      body_left--;
      cur_sop  = 1'b0;
      cur_eop  = (body_left == 0);
      cur_data = DW'($urandom);
    end
  endtask

  task automatic step(input logic v, input logic ordy);
    logic          s_ir, exp_ir;
    logic [BW-1:0] got, expb;
    int            c0;
    @(negedge clk);
    cycle++;
    s_ov = out_valid;
    s_ir = in_ready;
    exp_ir = ((acc_cnt - emit_cnt + 2) <= SKID);
    chk(s_ir == exp_ir, "R10 in_ready", 64'(s_ir), 64'(exp_ir));
    if (s_ov) begin
      chk(prev_out_ready, "R7 valid without prior ready", 1, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 spurious beat", 64'(out_data), 0);
      end else begin
        expb = exp_q.pop_front();
        c0   = cyc_q.pop_front();
        got  = {out_sop, out_eop, out_data};
        chk(got[DW-1:0] == expb[DW-1:0], expb[BW-1] ? "R3 header data" : "R4 pixel data",
            64'(got[DW-1:0]), 64'(expb[DW-1:0]));
        chk(got[BW-1:DW] == expb[BW-1:DW], "R5 framing", 64'(got[BW-1:DW]), 64'(expb[BW-1:DW]));
        if (exact_lat) chk((cycle - c0) == STG, "R6 latency", 64'(cycle - c0), STG);
        else           chk((cycle - c0) >= STG, "R6 min latency", 64'(cycle - c0), STG);
        emit_cnt++;
      end
    end
    in_valid  = v;
    in_data   = cur_data;
    in_sop    = cur_sop;
    in_eop    = cur_eop;
    out_ready = ordy;
    if (v && prev_in_ready) begin   // R2: acceptance follows prior-cycle ready
      exp_q.push_back({cur_sop, cur_eop, exp_pixel(cur_data, cur_sop)});
      cyc_q.push_back(cycle);
      acc_cnt++;
      load_next();
    end
    prev_in_ready  = s_ir;
    prev_out_ready = ordy;
  endtask

  task automatic do_reset();
    rst       = 1'b1;
    in_valid  = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 0);
    rst = 1'b0;
    exp_q.delete();
    cyc_q.delete();
    acc_cnt        = 0;
    emit_cnt       = 0;
    prev_out_ready = 1'b0;
    prev_in_ready  = in_ready;
    body_left      = 0;
    load_next();
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) step(1'b0, 1'b1);
    chk(exp_q.size() == 0, "R8 all beats delivered", 64'(exp_q.size()), 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int held;
    void'($urandom(32'd20240611));
    do_reset();
    step(1'b0, 1'b1);
    chk(s_ov == 1'b0, "R1 out_valid after reset", 64'(s_ov), 0);
    chk(prev_in_ready == 1'b1, "R1 in_ready after reset", 64'(prev_in_ready), 1);

    // Free-flowing output with input gaps: exact latency (R6, R9)
    exact_lat = 1'b1;
    step(1'b1, 1'b1);
    repeat (6) step(1'b0, 1'b1);
    for (int i = 0; i < 1500; i++) step(($urandom % 100) < 70, 1'b1);
    drain();

    // Random sink stalls: ordering and framing (R5, R7, R8)
    exact_lat = 1'b0;
    for (int i = 0; i < 3000; i++) step(($urandom % 100) < 60, ($urandom % 100) < 50);
    drain();

    // Stalled sink fills the store (R10), extra beats ignored (R2)
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
    chk((acc_cnt - emit_cnt) == SKID, "R10 held count at full", 64'(acc_cnt - emit_cnt), SKID);
    held = acc_cnt;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    chk(acc_cnt == held, "R2 no beat taken without ready", 64'(acc_cnt), 64'(held));
    drain();

    // Reset while full discards held beats (R1)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    do_reset();
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b1);
      chk(s_ov == 1'b0, "R1 nothing after reset", 64'(s_ov), 0);
    end
    finish_run();
  end

endmodule